// File: doc/BRIEF.md
# Paddle Game Session Controller

This block sequences one session of a single-player paddle-and-ball game. It starts in a rules phase with the ball held still. A button press starts live play with a fresh score and a full stock of balls. During play, every paddle hit adds one point. A miss takes away a ball and moves to a pause phase; once the pause has run its length, a button press requests a new ball and resumes play. The miss that uses up the last ball moves instead to an end-of-game phase, which returns to the rules phase on its own after a fixed number of frames.

The ball logic sends single-cycle hit and miss events, and a 60 Hz frame tick times the pause and end phases. The graphics and text logic read the play-enable flag, the new-ball pulse and the two text-select flags. They also read the score, held as BCD digits, and the balls-left count, so that both can be shown at the top of the screen at any time.

Top module: `paddle_session_top`

## Requirements
- R1: After reset the block is in the rules phase: showRules=1, playEn=0, showOver=0, newBall=0, score 00, ballsLeft=3.
- R2: In the rules phase, a button press makes playEn=1 from the next cycle. Without a button press the rules phase is held.
- R3: A hit in play raises the score by one on the next cycle. The score is two BCD digits (tens in bits 7:4, units in bits 3:0) and wraps from 99 to 00.
- R4: A miss in play clears playEn on the next cycle, enters the pause phase (all three flags low), and lowers ballsLeft by one.
- R5: newBall is a single-cycle pulse. It is raised in the cycle in which play resumes after a pause, and at no other time.
- R6: A button press in the pause phase has no effect until 120 frame ticks have been counted in that phase.
- R7: The miss that brings ballsLeft to 0 enters the end-of-game phase, with showOver=1 and playEn=0.
- R8: The end-of-game phase returns to the rules phase on the cycle after its 120th frame tick.
- R9: Hit and miss events outside the play phase change nothing. When hit and miss arrive in the same cycle, only the miss is acted on.
- R10: Starting a session from the rules phase clears the score to 00 and reloads ballsLeft to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btnPress | input | 1 | Debounced button-press pulse |
| frameTick | input | 1 | One-cycle pulse per frame (60 Hz) |
| hitEvt | input | 1 | Paddle hit event from the ball logic |
| missEvt | input | 1 | Ball missed event from the ball logic |
| playEn | output | 1 | Ball may move (play phase) |
| newBall | output | 1 | One-cycle request for a fresh ball |
| showRules | output | 1 | Select the rules text |
| showOver | output | 1 | Select the end-of-game text |
| scoreBcd | output | 8 | Score, two BCD digits |
| ballsLeft | output | 2 | Balls remaining in the session |

## Verification
Every output is registered. The result of an input sampled at one rising edge is therefore visible from that edge on, exactly one cycle later, and this holds for phase changes, score steps, ball count drops and the new-ball pulse alike. The driver changes inputs on the falling edge and, after the following rising edge, pushes the values it expects for that single cycle into the scoreboard. The monitor compares them at the next falling edge, so every cycle of the run is checked, including the full 120-tick pause and end windows.

// File: rtl/paddle_session_pkg.sv
package paddle_session_pkg;
  typedef enum logic [1:0] {
    PH_RULES = 2'd0,
    PH_PLAY  = 2'd1,
    PH_PAUSE = 2'd2,
    PH_OVER  = 2'd3
  } phase_e;

  typedef struct packed {
    logic clrSession;
    logic addPoint;
    logic takeBall;
  } dp_strobe_t;
endpackage

// File: rtl/paddle_session_ctrl.sv
module paddle_session_ctrl
  import paddle_session_pkg::*;
#(
  parameter int HOLD_TICKS = 120,
  parameter int BALL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btnPress,
  input  logic              frameTick,
  input  logic              hitEvt,
  input  logic              missEvt,
  input  logic [BALL_W-1:0] ballsLeft,
  output dp_strobe_t        strobe,
  output phase_e            phase,
  output logic              newBall
);
  localparam int HOLD_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);

  logic [HOLD_W-1:0] holdCnt;
  logic holdDone;
  logic lastTick;

  assign lastTick = frameTick && (holdCnt == HOLD_LAST);

  always_comb begin
    strobe.clrSession = (phase == PH_RULES) && btnPress;
    strobe.takeBall   = (phase == PH_PLAY) && missEvt;
    strobe.addPoint   = (phase == PH_PLAY) && hitEvt && !missEvt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_RULES;
      holdCnt  <= '0;
      holdDone <= 1'b0;
      newBall  <= 1'b0;
    end else begin
      newBall <= 1'b0;
      unique case (phase)
        PH_RULES: if (btnPress) phase <= PH_PLAY;
        PH_PLAY: begin
          if (missEvt) begin
            holdCnt  <= '0;
            holdDone <= 1'b0;
            phase    <= (ballsLeft == BALL_W'(1)) ? PH_OVER : PH_PAUSE;
          end
        end
        PH_PAUSE: begin
          if (holdDone && btnPress) begin
            phase   <= PH_PLAY;
            newBall <= 1'b1;
          end else if (frameTick && !holdDone) begin
            if (lastTick) begin
              holdDone <= 1'b1;
              holdCnt  <= '0;
            end else begin
              holdCnt <= holdCnt + 1'b1;
            end
          end
        end
        PH_OVER: begin
          if (lastTick) begin
            phase   <= PH_RULES;
            holdCnt <= '0;
          end else if (frameTick) begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        default: phase <= PH_RULES;
      endcase
    end
  end
endmodule

// File: rtl/paddle_session_dp.sv
module paddle_session_dp
  import paddle_session_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter int BALLS = 3,
  parameter int BALL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dp_strobe_t            strobe,
  output logic [4*DIGITS-1:0]   scoreBcd,
  output logic [BALL_W-1:0]     ballsLeft
);
  logic [DIGITS:0] carry;
  assign carry[0] = strobe.addPoint;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] digitQ;
    assign carry[d+1] = carry[d] && (digitQ == 4'd9);
    assign scoreBcd[4*d +: 4] = digitQ;

    always_ff @(posedge clk) begin
      if (rst || strobe.clrSession) digitQ <= 4'd0;
      else if (carry[d]) digitQ <= (digitQ == 4'd9) ? 4'd0 : digitQ + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrSession) ballsLeft <= BALL_W'(BALLS);
    else if (strobe.takeBall && ballsLeft != '0) ballsLeft <= ballsLeft - 1'b1;
  end
endmodule

// File: rtl/paddle_session_top.sv
module paddle_session_top
  import paddle_session_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter int BALLS = 3,
  parameter int HOLD_TICKS = 120,
  localparam int BALL_W = $clog2(BALLS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                btnPress,
  input  logic                frameTick,
  input  logic                hitEvt,
  input  logic                missEvt,
  output logic                playEn,
  output logic                newBall,
  output logic                showRules,
  output logic                showOver,
  output logic [4*DIGITS-1:0] scoreBcd,
  output logic [BALL_W-1:0]   ballsLeft
);
  dp_strobe_t strobe;
  phase_e phase;

  paddle_session_ctrl #(.HOLD_TICKS(HOLD_TICKS), .BALL_W(BALL_W)) u_ctrl (
    .clk(clk), .rst(rst), .btnPress(btnPress), .frameTick(frameTick),
    .hitEvt(hitEvt), .missEvt(missEvt), .ballsLeft(ballsLeft),
    .strobe(strobe), .phase(phase), .newBall(newBall)
  );

  paddle_session_dp #(.DIGITS(DIGITS), .BALLS(BALLS), .BALL_W(BALL_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .scoreBcd(scoreBcd), .ballsLeft(ballsLeft)
  );

  assign playEn    = (phase == PH_PLAY);
  assign showRules = (phase == PH_RULES);
  assign showOver  = (phase == PH_OVER);
endmodule

// File: rtl/paddle_session_chk.sv
module paddle_session_chk #(
  parameter int DIGITS = 2,
  parameter int BALL_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                btnPress,
  input logic                missEvt,
  input logic                playEn,
  input logic                newBall,
  input logic                showRules,
  input logic                showOver,
  input logic [4*DIGITS-1:0] scoreBcd,
  input logic [BALL_W-1:0]   ballsLeft
);
  assert_one_phase_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({playEn, showRules, showOver}));

  assert_rules_start_R2: assert property (@(posedge clk) disable iff (rst)
    (showRules && btnPress) |=> playEn);

  assert_miss_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (playEn && missEvt) |=> (!playEn && ballsLeft == $past(ballsLeft) - 1'b1));

  assert_pulse_once_R5: assert property (@(posedge clk) disable iff (rst)
    newBall |=> !newBall);

  assert_pulse_in_play_R5: assert property (@(posedge clk) disable iff (rst)
    newBall |-> playEn);

  assert_over_empty_R7: assert property (@(posedge clk) disable iff (rst)
    showOver |-> (ballsLeft == '0));

  assert_score_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!playEn && !showRules) |=> $stable(scoreBcd));

  for (genvar d = 0; d < DIGITS; d++) begin : g_bcd
    assert_bcd_digit_R3: assert property (@(posedge clk) disable iff (rst)
      scoreBcd[4*d +: 4] <= 4'd9);
  end
endmodule

bind paddle_session_top paddle_session_chk #(.DIGITS(DIGITS), .BALL_W(BALL_W)) u_chk (.*);

// File: tb/paddle_session_top_bench.sv
module paddle_session_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnPress = 1'b0, frameTick = 1'b0, hitEvt = 1'b0, missEvt = 1'b0;
  logic playEn, newBall, showRules, showOver;
  logic [7:0] scoreBcd;
  logic [1:0] ballsLeft;

  always #2 clk = ~clk;

  paddle_session_top u_paddle_session_top (.*);

  typedef struct packed {
    logic [7:0] score;
    logic [1:0] balls;
    logic play, rules, over, nb;
  } exp_t;

  exp_t expQ[$];
  string tagQ[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model (0 rules, 1 play, 2 pause, 3 over)
  int mPh = 0, mScore = 0, mBalls = 3, mCnt = 0;
  bit mDone = 0, mNb = 0;

  function automatic exp_t modelExp();
    exp_t e;
    e.score = 8'((mScore / 10) * 16 + (mScore % 10));
    e.balls = 2'(mBalls);
    e.play = (mPh == 1); e.rules = (mPh == 0); e.over = (mPh == 3);
    e.nb = mNb;
    return e;
  endfunction

  task automatic step(input bit b, input bit tk, input bit h, input bit m, input string tag);
    @(negedge clk);
    btnPress = b; frameTick = tk; hitEvt = h; missEvt = m;
    mNb = 0;
    case (mPh)
      0: if (b) begin mPh = 1; mScore = 0; mBalls = 3; end
      1: begin
        if (m) begin
          mBalls--; mCnt = 0; mDone = 0;
          mPh = (mBalls == 0) ? 3 : 2;
        end else if (h) mScore = (mScore + 1) % 100;
      end
      2: begin
        if (mDone && b) begin mPh = 1; mNb = 1; end
        else if (tk && !mDone) begin
          if (mCnt == 119) begin mDone = 1; mCnt = 0; end else mCnt++;
        end
      end
      default: if (tk) begin
        if (mCnt == 119) begin mPh = 0; mCnt = 0; end else mCnt++;
      end
    endcase
    @(posedge clk); #1;
    expQ.push_back(modelExp());
    tagQ.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      exp_t e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = {scoreBcd, ballsLeft, playEn, showRules, showOver, newBall};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual score=%h balls=%0d play=%b rules=%b over=%b nb=%b expected score=%h balls=%0d play=%b rules=%b over=%b nb=%b",
                 t, a.score, a.balls, a.play, a.rules, a.over, a.nb,
                 e.score, e.balls, e.play, e.rules, e.over, e.nb);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    expQ.push_back(modelExp()); tagQ.push_back("R1 reset state");
    // events outside play ignored
    step(0, 1, 1, 0, "R9 hit in rules");
    step(0, 0, 0, 1, "R9 miss in rules");
    step(0, 0, 0, 0, "R2 rules held");
    step(1, 0, 0, 0, "R2 start play");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, "R3 hit adds one");
    step(0, 0, 1, 1, "R9 miss priority / R4 pause");
    step(0, 0, 1, 0, "R9 hit in pause");
    for (int i = 0; i < 119; i++) step(i == 50, 1, 0, 0, "R6 early button ignored");
    step(1, 0, 0, 0, "R6 button before last tick");
    step(0, 1, 0, 0, "R6 last tick");
    step(1, 0, 0, 0, "R5 new ball");
    step(0, 0, 0, 0, "R5 pulse ends");
    for (int i = 0; i < 100; i++) step(0, 0, 1, 0, "R3 wrap 99 to 00");
    step(0, 0, 0, 1, "R4 second miss");
    for (int i = 0; i < 120; i++) step(0, 1, 0, 0, "R6 pause count");
    step(1, 0, 0, 0, "R5 resume");
    step(0, 0, 1, 0, "R3 hit after resume");
    step(0, 0, 0, 1, "R7 third miss");
    step(1, 0, 1, 1, "R9 events in over");
    for (int i = 0; i < 120; i++) step(0, 1, 0, 0, "R8 end phase then rules");
    step(0, 0, 0, 0, "R8 rules shown");
    step(1, 0, 0, 0, "R10 new session clears");
    step(0, 0, 1, 0, "R10 first point");
    step(0, 0, 0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule